// File: doc/BRIEF.md
# Time-Multiplexed Nine-Tap Low-Pass FIR Filter

This block low-pass filters a stream of 16-bit signed samples with a fixed nine-tap response. Two clocks come in. A slow sample clock says when a new input value is ready. A faster processing clock runs all the logic. The sample clock is treated as a data signal: it is synchronized into the fast domain, and each rising edge pushes the current input word into a nine-entry delay line.

A single multiplier and accumulator then walks the nine taps, one tap per fast cycle. When it has finished, the sum is rounded, saturated and placed in a held output register. A one-cycle strobe marks each new result.

The block suits designs where the fast clock is many times the sample rate. In those designs one shared multiplier costs far less than nine parallel ones. The coefficients are constants with 16 fractional bits, and their sum is symmetric. The output keeps the integer part of the accumulated sum.

Top module: `fir_tdm_lowpass`

## Requirements
- R1: `din` and `dout` are 16-bit two's-complement. Each result equals the sum over k = 0..8 of c[k]·x[n−k], where x[n] is the newest sample. The coefficients are c = {−62, 396, 5020, 14346, 19660, 14346, 5020, 396, −62} for k = 0..8, and the sum is then rescaled as R4 describes.
- R2: `samp_clk` passes through a two-flop synchronizer. Each rising edge starts exactly one computation. The value of `din` is captured in the fast cycle in which the synchronized edge is seen, so `din` must stay stable for at least three fast cycles after `samp_clk` rises.
- R3: The accumulator is 36 bits signed. No input sequence, including full-scale values of alternating sign, makes it wrap.
- R4: The rescaled value is (sum + 2^15) shifted right arithmetically by 16 bits. This is round-half-up, and it is the same as taking bits [31:16] of the biased sum.
- R5: The rescaled value is clamped to the range −32768 to 32767 before it reaches `dout`.
- R6: The response is low-pass. A constant input x settles, after nine samples, to round(x·59060/2^16). A step in a square wave produces a ramp: outputs rise strictly over the later samples of a high half-period.
- R7: `dout_valid` rises exactly 11 fast cycles after the cycle in which the computation was accepted. That is 1 cycle for the capture, 9 cycles for multiply-accumulate and 1 cycle for the output write. The sample period must therefore be at least 11 fast cycles.
- R8: `dout_valid` is high for exactly one fast cycle per accepted sample. `dout` does not change in any cycle in which `dout_valid` is low.
- R9: A sample-clock edge that arrives while a computation is running is ignored. It does not shift the delay line and it produces no result.
- R10: Synchronous active-high `rst` clears the delay line, the accumulator, `dout` and `dout_valid`. It also drops any computation in progress, so no strobe follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_clk | input | 1 | Sample clock; a rising edge marks a new input sample |
| din | input | 16 | Signed input sample |
| dout | output | 16 | Signed filtered output, held between updates |
| dout_valid | output | 1 | One-cycle strobe on each new `dout` |

## Verification
The following properties are checked on every cycle:
- the synchronized edge pulse lasts exactly one cycle;
- the result strobe arrives exactly 11 cycles after an accepted start;
- the strobe is never longer than one cycle;
- `dout` holds while no strobe is present;
- reset leaves `dout` and the strobe clear.

Only the bench scenarios can show the following:
- the numeric results, including the rounding, the absence of wrap at full scale, the DC gain and the ramped square-wave response;
- that an edge arriving while busy is dropped from the delay line;
- that a mid-computation reset leaves no trace in the next result.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int DATA_W  = 16;
    localparam int COEF_W  = 16;
    localparam int NTAPS   = 9;
    localparam int FRAC_W  = 16;
    localparam int PROD_W  = DATA_W + COEF_W;
    localparam int ACC_W   = PROD_W + $clog2(NTAPS);
    localparam int IDX_W   = $clog2(NTAPS);
    localparam int LATENCY = NTAPS + 2;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [IDX_W-1:0]         tap_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_WRITE
    } seq_state_t;

    typedef struct packed {
        seq_state_t state;
        tap_idx_t   idx;
    } seq_ctl_t;

    localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((2 ** (DATA_W-1)) - 1);
    localparam logic signed [ACC_W:0] SAT_LO = ~SAT_HI;
    localparam logic signed [ACC_W:0] ROUND_BIAS = (ACC_W+1)'(2 ** (FRAC_W-1));

    // Low-pass response, newest sample first, Q16 fixed point.
    function automatic coef_t tap_coef(input tap_idx_t i);
        case (i)
            4'd0:    return coef_t'(-62);
            4'd1:    return coef_t'(396);
            4'd2:    return coef_t'(5020);
            4'd3:    return coef_t'(14346);
            4'd4:    return coef_t'(19660);
            4'd5:    return coef_t'(14346);
            4'd6:    return coef_t'(5020);
            4'd7:    return coef_t'(396);
            4'd8:    return coef_t'(-62);
            default: return '0;
        endcase
    endfunction

    // Round half up, drop the Q16 scaling, clamp to the sample range.
    function automatic sample_t round_sat(input acc_t a);
        logic signed [ACC_W:0] biased;
        logic signed [ACC_W:0] shifted;
        biased  = {a[ACC_W-1], a} + ROUND_BIAS;
        shifted = biased >>> FRAC_W;
        if (shifted > SAT_HI)
            return SAT_HI[DATA_W-1:0];
        else if (shifted < SAT_LO)
            return SAT_LO[DATA_W-1:0];
        else
            return shifted[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/fir_edge_sync.sv
module fir_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // One extra flop beyond the synchronizer keeps the previous level.
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[SYNC_STAGES-1:0], async_in};
    end

    assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line
    import fir_pkg::*;
#(
    parameter int N = NTAPS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     shift_en,
    input  sample_t  din,
    input  tap_idx_t sel,
    output sample_t  tap_out
);
    sample_t taps [N];

    always_ff @(posedge clk) begin
        if (rst)
            taps[0] <= '0;
        else if (shift_en)
            taps[0] <= din;
    end

    for (genvar k = 1; k < N; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                taps[k] <= '0;
            else if (shift_en)
                taps[k] <= taps[k-1];
        end
    end

    always_comb begin
        tap_out = '0;
        for (int k = 0; k < N; k++)
            if (sel == tap_idx_t'(k))
                tap_out = taps[k];
    end
endmodule

// File: rtl/fir_mac.sv
module fir_mac
    import fir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    en,
    input  coef_t   coef,
    input  sample_t sample,
    output acc_t    acc
);
    logic signed [PROD_W-1:0] prod;
    acc_t                     prod_ext;

    assign prod     = coef * sample;
    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (en)
            acc <= acc + prod_ext;
    end
endmodule

// File: rtl/fir_seq.sv
module fir_seq
    import fir_pkg::*;
#(
    parameter int N = NTAPS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output logic     accept,
    output logic     busy,
    output logic     mac_en,
    output logic     out_wr,
    output tap_idx_t idx
);
    seq_ctl_t ctl;

    always_comb begin
        accept = start && (ctl.state == ST_IDLE);
        busy   = (ctl.state != ST_IDLE);
        mac_en = (ctl.state == ST_MAC);
        out_wr = (ctl.state == ST_WRITE);
        idx    = ctl.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.state <= ST_IDLE;
            ctl.idx   <= '0;
        end else begin
            case (ctl.state)
                ST_IDLE: begin
                    if (start) begin
                        ctl.state <= ST_MAC;
                        ctl.idx   <= '0;
                    end
                end
                ST_MAC: begin
                    if (ctl.idx == tap_idx_t'(N-1))
                        ctl.state <= ST_WRITE;
                    else
                        ctl.idx <= ctl.idx + 1'b1;
                end
                ST_WRITE: ctl.state <= ST_IDLE;
                default:  ctl.state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fir_tdm_lowpass.sv
module fir_tdm_lowpass
    import fir_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     samp_clk,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout,
    output logic                     dout_valid
);
    logic     samp_rise;
    logic     seq_accept;
    logic     seq_busy;
    logic     mac_en;
    logic     out_wr;
    tap_idx_t tap_sel;
    sample_t  tap_val;
    acc_t     acc;
    sample_t  dout_q;
    logic     valid_q;

    fir_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (samp_clk),
        .rise     (samp_rise)
    );

    fir_seq #(.N(NTAPS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (samp_rise),
        .accept (seq_accept),
        .busy   (seq_busy),
        .mac_en (mac_en),
        .out_wr (out_wr),
        .idx    (tap_sel)
    );

    fir_delay_line #(.N(NTAPS)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .shift_en (seq_accept),
        .din      (din),
        .sel      (tap_sel),
        .tap_out  (tap_val)
    );

    fir_mac u_mac (
        .clk    (clk),
        .rst    (rst),
        .clr    (seq_accept),
        .en     (mac_en),
        .coef   (tap_coef(tap_sel)),
        .sample (tap_val),
        .acc    (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= out_wr;
            if (out_wr)
                dout_q <= round_sat(acc);
        end
    end

    assign dout       = dout_q;
    assign dout_valid = valid_q;
endmodule

// File: rtl/fir_tdm_lowpass_chk.sv
module fir_tdm_lowpass_chk
    import fir_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     accept,
    input logic                     busy,
    input logic signed [DATA_W-1:0] dout,
    input logic                     dout_valid
);
    localparam int CNT_W = $clog2(LATENCY + 2) + 1;
    logic [CNT_W-1:0] since_accept;

    always_ff @(posedge clk) begin
        if (rst)
            since_accept <= '0;
        else if (accept)
            since_accept <= CNT_W'(1);
        else if (since_accept != '0 && since_accept != {CNT_W{1'b1}})
            since_accept <= since_accept + 1'b1;
    end

    // R2: a synchronized sample edge yields a single-cycle start pulse
    a_r2_single_start: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R9: an accepted start always leaves the sequencer busy
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R7: the result strobe lands a fixed number of cycles after acceptance
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> (since_accept == CNT_W'(LATENCY)));

    // R8: the strobe lasts one cycle
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> !dout_valid);

    // R8: the output holds while no strobe is present
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> $stable(dout));

    // R10: reset clears the result and the strobe
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (dout == '0 && !dout_valid));
endmodule

bind fir_tdm_lowpass fir_tdm_lowpass_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (samp_rise),
    .accept     (seq_accept),
    .busy       (seq_busy),
    .dout       (dout),
    .dout_valid (dout_valid)
);

// File: tb/fir_tdm_lowpass_test.sv
`timescale 1ns/1ps
module fir_tdm_lowpass_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               samp_clk = 1'b0;
    logic signed [15:0] din = '0;
    logic signed [15:0] dout;
    logic               dout_valid;

    int checks = 0;
    int fails  = 0;
    longint hist [9];
    logic signed [15:0] prev_dout;

    always #2.5 clk = ~clk;

    fir_tdm_lowpass uut (
        .clk        (clk),
        .rst        (rst),
        .samp_clk   (samp_clk),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    function automatic longint coef_of(input int k);
        case (k)
            0, 8:    return -62;
            1, 7:    return 396;
            2, 6:    return 5020;
            3, 5:    return 14346;
            default: return 19660;
        endcase
    endfunction

    function automatic longint rescale(input longint s);
        longint r;
        r = (s + 32768) >>> 16;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic longint model_out();
        longint s = 0;
        for (int k = 0; k < 9; k++) s += coef_of(k) * hist[k];
        return rescale(s);
    endfunction

    task automatic model_push(input int x);
        for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
    endtask

    task automatic model_clear();
        for (int k = 0; k < 9; k++) hist[k] = 0;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Watch the outputs for a window; count strobes and check the hold rule (R8).
    task automatic observe(input int cycles, input int drop_at, output int pulses, output longint got);
        pulses = 0;
        got = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (i == drop_at) samp_clk = 1'b0;
            if (dout_valid) begin
                pulses++;
                got = dout;
            end else if (dout !== prev_dout) begin
                check(1'b0, "R8 hold", dout, prev_dout);
            end
            prev_dout = dout;
        end
    endtask

    task automatic send_sample(input int x, input string req, output longint got);
        int pulses;
        @(negedge clk);
        din = 16'(x);
        samp_clk = 1'b1;
        observe(28, 5, pulses, got);
        model_push(x);
        check(pulses == 1, "R8 one strobe", pulses, 1);
        check(got == model_out(), req, got, model_out());
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        longint got, prev;
        int pulses;
        void'($urandom(32'd2718));
        model_clear();

        // Reset state (R10)
        repeat (4) @(negedge clk);
        check(dout == 0, "R10 reset dout", dout, 0);
        check(dout_valid == 0, "R10 reset strobe", dout_valid, 0);
        rst = 1'b0;
        prev_dout = dout;

        // Impulse response (R1, R4)
        send_sample(32767, "R1 impulse", got);
        for (int i = 0; i < 9; i++) send_sample(0, "R1 impulse tail", got);
        send_sample(1, "R4 round small", got);
        send_sample(-3, "R4 round negative", got);
        send_sample(5957, "R4 round mid", got);

        // DC gain (R6)
        for (int i = 0; i < 12; i++) send_sample(20000, "R6 dc", got);
        check(got == rescale(longint'(20000) * 59060), "R6 dc gain", got, rescale(longint'(20000) * 59060));

        // Full-scale alternating signs against coefficient signs (R3, R5)
        for (int i = 0; i < 9; i++)
            send_sample((i == 0 || i == 8) ? 32767 : -32768, "R3 full scale neg", got);
        for (int i = 0; i < 9; i++)
            send_sample((i == 0 || i == 8) ? -32768 : 32767, "R5 full scale pos", got);

        // Square wave: ramped edges (R6)
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 8; i++) send_sample(-12000, "R6 square low", got);
            for (int i = 0; i < 8; i++) begin
                send_sample(12000, "R6 square high", got);
                if (i >= 2) check(got > prev, "R6 ramp rising", got, prev + 1);
                prev = got;
            end
        end

        // Random samples (R1)
        for (int i = 0; i < 60; i++)
            send_sample(int'($urandom_range(65535)) - 32768, "R1 random", got);

        // Edge during a busy computation is dropped (R9)
        @(negedge clk);
        din = 16'sd7000;
        samp_clk = 1'b1;
        repeat (2) @(negedge clk);
        samp_clk = 1'b0;
        repeat (2) @(negedge clk);
        din = 16'sd31111;
        samp_clk = 1'b1;
        observe(30, 1, pulses, got);
        model_push(7000);
        check(pulses == 1, "R9 busy edge strobes", pulses, 1);
        check(got == model_out(), "R9 first result", got, model_out());
        send_sample(-4000, "R9 dropped sample absent", got);

        // Reset in mid-computation (R10)
        @(negedge clk);
        din = 16'sd25000;
        samp_clk = 1'b1;
        repeat (2) @(negedge clk);
        samp_clk = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        prev_dout = dout;
        observe(20, 0, pulses, got);
        model_clear();
        check(pulses == 0, "R10 dropped computation", pulses, 0);
        check(dout == 0, "R10 dout cleared", dout, 0);
        send_sample(10000, "R10 delay line cleared", got);
        check(got == -9, "R10 single tap", got, -9);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule